// File: doc/BRIEF.md
# Burst Column Address Generator

This block sits beside the command sequencer of a synchronous DRAM controller and produces the column address for every beat of a read or write burst. Software, or the initialisation sequence, programs a mode key once. The key sets the burst length (1, 2, 4, 8 or a whole page) and the beat ordering (sequential or interleaved). It also holds a flag that limits every write to a single location while reads keep the programmed length.

A burst begins with a one-cycle `start` pulse that carries the first column and says whether the access is a write. The block then offers one column per beat on a valid/ready pair. `beat_valid` stays high while a burst is in progress and doubles as the busy indication. A beat is taken only in a cycle where `beat_valid` and `beat_ready` are both high. While `beat_ready` is low, the offered column and `last` hold steady, so the consumer can apply back-pressure for any number of cycles.

Finite bursts end on their own after the last beat is taken. A page burst wraps through all 256 columns and keeps going until a `stop` pulse arrives. A new `start` during a burst abandons the old burst and begins the new one.

Top module: `burst_col_gen`

## Requirements
- R1: A `mode_we` pulse stores `mode_key` from the next cycle on. Bits 2:0 hold the length code, where 000, 001, 010, 011 and 111 mean 1, 2, 4, 8 beats and page. Bit 3 selects interleave when set. Bit 9 set means single-location writes and is driven on `single_write`.
- R2: In the cycle after `start`, `beat_valid` is 1 and `col` equals the start column.
- R3: While `beat_valid` is 1 and `beat_ready` is 0, and no start or stop is given, `col` and `beat_valid` keep their values into the next cycle.
- R4: In sequential order, the low log2(L) bits of beat i are (start offset + i) mod L.
- R5: In interleaved order, the low log2(L) bits of beat i are start offset XOR i.
- R6: In finite bursts, the column bits above the low log2(L) stay equal to those of the start column.
- R7: A page burst gives start column + i mod 256, ignores the interleave bit, and never raises `last`.
- R8: `last` is 1 only on the final beat of a finite burst. After that beat is taken, `beat_valid` is 0 in the next cycle.
- R9: `stop` ends a burst so that `beat_valid` is 0 in the next cycle. `stop`, or `beat_ready`, given while idle has no effect.
- R10: The reserved length codes 100, 101 and 110 give one-beat bursts.
- R11: With bit 9 set, a write burst has one beat. Read bursts keep the programmed length.
- R12: Length and order are captured at `start`. A mode write during a burst does not change that burst.
- R13: A `start` during a burst restarts it from the new start column, with the length and order in force at that moment.
- R14: After reset, `beat_valid`, `last` and `single_write` are 0, and the mode is one beat, sequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_we | input | 1 | Store `mode_key` as the new mode |
| mode_key | input | KEY_W (12) | Mode key: length code, order bit, single-write bit |
| start | input | 1 | Begin a burst (one-cycle pulse) |
| start_col | input | COL_W (8) | First column of the burst |
| start_wr | input | 1 | The burst being started is a write |
| stop | input | 1 | End the current burst |
| beat_valid | output | 1 | A beat column is offered; also the busy flag |
| beat_ready | input | 1 | Consumer takes the offered beat |
| col | output | COL_W (8) | Column of the offered beat |
| last | output | 1 | The offered beat is the final beat of a finite burst |
| single_write | output | 1 | Writes are limited to one location |

## Verification
The checker watches, on every cycle, the rules that relate neighbouring cycles. These are: start loading the column, stalls holding the beat, the end after a taken last beat, stop ending a burst, upper column bits staying fixed, page bursts never raising `last`, and the mode bit reaching `single_write`. The actual beat sequences can only be shown by the bench scenarios. Those scenarios cover the sequential and interleaved orders for each length, the page wrap past column 255, the reserved codes, and single-write versus read lengths. They also cover a mode change during a burst and a restart, with the scoreboard comparing every taken beat against a model.

// File: rtl/bcol_pkg.sv
package bcol_pkg;
  localparam int COL_W = 8;

  typedef enum logic [2:0] {
    BL_ONE  = 3'b000,
    BL_TWO  = 3'b001,
    BL_FOUR = 3'b010,
    BL_EIGHT= 3'b011,
    BL_PAGE = 3'b111
  } blen_code_e;

  typedef struct packed {
    logic [COL_W-1:0] mask;       // beat count minus one, page = all ones
    logic             interleave;
    logic             full_page;
  } burst_cfg_t;

  function automatic burst_cfg_t decode_cfg(input logic [2:0] code,
                                            input logic       type_bit,
                                            input logic       one_beat);
    burst_cfg_t c;
    c.mask      = '0;
    c.full_page = 1'b0;
    case (code)
      BL_TWO:   c.mask = COL_W'(1);
      BL_FOUR:  c.mask = COL_W'(3);
      BL_EIGHT: c.mask = COL_W'(7);
      BL_PAGE: begin
        c.mask      = '1;
        c.full_page = 1'b1;
      end
      default:  c.mask = '0;
    endcase
    if (one_beat) begin
      c.mask      = '0;
      c.full_page = 1'b0;
    end
    c.interleave = type_bit & ~c.full_page;
    return c;
  endfunction
endpackage

// File: rtl/bcol_mode_reg.sv
module bcol_mode_reg #(
  parameter int KEY_W   = 12,
  parameter int TYPE_B  = 3,
  parameter int SW_B    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_we,
  input  logic [KEY_W-1:0] mode_key,
  output logic [2:0]       len_code,
  output logic             type_bit,
  output logic             single_wr
);
  logic [KEY_W-1:0] key_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       key_q <= '0;
    else if (mode_we) key_q <= mode_key;
  end

  assign len_code  = key_q[2:0];
  assign type_bit  = key_q[TYPE_B];
  assign single_wr = key_q[SW_B];
endmodule

// File: rtl/bcol_ctrl.sv
module bcol_ctrl
  import bcol_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_wr,
  input  logic             stop,
  input  logic             take,
  input  logic [2:0]       len_code,
  input  logic             type_bit,
  input  logic             single_wr,
  output logic             busy,
  output logic [COL_W-1:0] base_col,
  output logic [COL_W-1:0] beat_cnt,
  output burst_cfg_t       cfg,
  output logic             last
);
  assign last = busy & ~cfg.full_page & (beat_cnt == cfg.mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      base_col <= '0;
      beat_cnt <= '0;
      cfg      <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      base_col <= start_col;
      beat_cnt <= '0;
      cfg      <= decode_cfg(len_code, type_bit, start_wr & single_wr);
    end else if (stop) begin
      busy     <= 1'b0;
    end else if (take) begin
      if (last) busy <= 1'b0;
      else      beat_cnt <= beat_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bcol_calc.sv
module bcol_calc
  import bcol_pkg::*;
(
  input  logic [COL_W-1:0] base_col,
  input  logic [COL_W-1:0] beat_cnt,
  input  burst_cfg_t       cfg,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] low_seq, low_xor, low_sel;

  always_comb begin
    low_seq = base_col + beat_cnt;
    low_xor = base_col ^ beat_cnt;
    low_sel = cfg.interleave ? low_xor : low_seq;
    col     = (base_col & ~cfg.mask) | (low_sel & cfg.mask);
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcol_pkg::*;
#(
  parameter int KEY_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_we,
  input  logic [KEY_W-1:0] mode_key,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_wr,
  input  logic             stop,
  output logic             beat_valid,
  input  logic             beat_ready,
  output logic [COL_W-1:0] col,
  output logic             last,
  output logic             single_write
);
  logic [2:0]       len_code;
  logic             type_bit;
  logic             busy;
  logic [COL_W-1:0] base_col, beat_cnt;
  burst_cfg_t       act_cfg;
  logic             take;

  bcol_mode_reg #(.KEY_W(KEY_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_key(mode_key),
    .len_code(len_code), .type_bit(type_bit), .single_wr(single_write)
  );

  assign take = busy & beat_ready;

  bcol_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .start_wr(start_wr), .stop(stop), .take(take), .len_code(len_code),
    .type_bit(type_bit), .single_wr(single_write), .busy(busy),
    .base_col(base_col), .beat_cnt(beat_cnt), .cfg(act_cfg), .last(last)
  );

  bcol_calc u_calc (
    .base_col(base_col), .beat_cnt(beat_cnt), .cfg(act_cfg), .col(col)
  );

  assign beat_valid = busy;
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int KEY_W = 12,
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_we,
  input logic [KEY_W-1:0] mode_key,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic             stop,
  input logic             beat_valid,
  input logic             beat_ready,
  input logic [COL_W-1:0] col,
  input logic             last,
  input logic             single_write,
  input logic [COL_W-1:0] cfg_mask,
  input logic             cfg_page
);
  // R1
  mode_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> single_write == $past(mode_key[9]));
  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> beat_valid && col == $past(start_col));
  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready && !start && !stop |=> beat_valid && $stable(col));
  // R6
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && !last && !start && !stop
      |=> ((col ^ $past(col)) & ~$past(cfg_mask)) == '0);
  // R7
  page_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && cfg_page |-> !last);
  // R8
  last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && last && !start |=> !beat_valid);
  // R8
  idle_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_valid |-> !last);
  // R9
  stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop && !start |=> !beat_valid);
endmodule

bind burst_col_gen burst_col_gen_chk #(.KEY_W(KEY_W), .COL_W(bcol_pkg::COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_key(mode_key),
  .start(start), .start_col(start_col), .stop(stop), .beat_valid(beat_valid),
  .beat_ready(beat_ready), .col(col), .last(last), .single_write(single_write),
  .cfg_mask(act_cfg.mask), .cfg_page(act_cfg.full_page)
);

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;
  logic        clk = 0, rst_n = 0;
  logic        mode_we = 0, start = 0, start_wr = 0, stop = 0, beat_ready = 0;
  logic [11:0] mode_key = '0;
  logic [7:0]  start_col = '0;
  logic        beat_valid, last, single_write;
  logic [7:0]  col;

  int total = 0, bad = 0;
  logic [2:0] m_code = 0;
  logic       m_inter = 0, m_sw = 0;

  logic [7:0] q_col[$];
  logic       q_last[$];
  string      q_tag[$];

  always #4 clk = ~clk;

  burst_col_gen i_burst_col_gen (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_key(mode_key),
    .start(start), .start_col(start_col), .start_wr(start_wr), .stop(stop),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .col(col), .last(last),
    .single_write(single_write)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pop and compare every taken beat
  initial forever begin
    @(negedge clk);
    if (rst_n && beat_valid && beat_ready) begin
      if (q_col.size() == 0) check(0, "unexpected beat", col, 0);
      else begin
        automatic logic [7:0] ec = q_col.pop_front();
        automatic logic el = q_last.pop_front();
        automatic string tg = q_tag.pop_front();
        check(col == ec, {tg, " col"}, col, ec);
        check(last == el, {tg, " last"}, last, el);
      end
    end
  end

  task automatic set_mode(input logic [2:0] code, input logic inter, input logic sw);
    @(posedge clk); #1;
    mode_we = 1; mode_key = '0;
    mode_key[2:0] = code; mode_key[3] = inter; mode_key[9] = sw;
    mode_key[6:4] = 3'd2;
    @(posedge clk); #1;
    mode_we = 0;
    m_code = code; m_inter = inter; m_sw = sw;
  endtask

  // endm: 0 natural end, 1 stop, 2 leave running
  task automatic run_burst(input logic [7:0] sc, input logic wr, input int take_n,
                           input int endm, input bit stall, input bit mid_mode,
                           input string tag);
    int len; bit page; int msk; int got; int cyc;
    page = 0;
    case (m_code)
      3'b001: len = 2;
      3'b010: len = 4;
      3'b011: len = 8;
      3'b111: begin len = 256; page = 1; end
      default: len = 1;
    endcase
    if (wr && m_sw) begin len = 1; page = 0; end
    msk = len - 1;
    for (int i = 0; i < take_n; i++) begin
      automatic int lo = (m_inter && !page) ? (int'(sc) ^ i) : (int'(sc) + i);
      q_col.push_back(8'((int'(sc) & ~msk) | (lo & msk)));
      q_last.push_back(!page && i == len - 1);
      q_tag.push_back(tag);
    end
    @(posedge clk); #1;
    start = 1; start_col = sc; start_wr = wr;
    @(posedge clk); #1;
    start = 0;
    if (mid_mode) begin
      mode_we = 1; mode_key = 12'h00B;   // length 8, interleaved
    end
    got = 0; cyc = 0;
    while (got < take_n) begin
      beat_ready = stall ? (cyc % 3 != 1) : 1'b1;
      @(negedge clk);
      if (beat_valid && beat_ready) got++;
      @(posedge clk); #1;
      mode_we = 0;
      cyc++;
    end
    beat_ready = 0;
    if (mid_mode) begin m_code = 3'b011; m_inter = 1; end
    check(q_col.size() == 0, {tag, " beats taken"}, q_col.size(), 0);
    if (endm == 0) check(!beat_valid, {tag, " ends after last (R8)"}, beat_valid, 0);
    else if (endm == 1) begin
      check(beat_valid, {tag, " still busy before stop"}, beat_valid, 1);
      stop = 1;
      @(posedge clk); #1;
      stop = 0;
      check(!beat_valid, {tag, " stop ends burst (R9)"}, beat_valid, 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R14 reset state
    check(!beat_valid, "R14 valid", beat_valid, 0);
    check(!last, "R14 last", last, 0);
    check(!single_write, "R14 single_write", single_write, 0);
    run_burst(8'h37, 0, 1, 0, 0, 0, "R14 default one beat");

    set_mode(3'b001, 0, 0);
    run_burst(8'h35, 0, 2, 0, 0, 0, "R4 seq len2");
    set_mode(3'b010, 0, 0);
    run_burst(8'h66, 0, 4, 0, 0, 0, "R4 R6 seq len4");
    set_mode(3'b011, 0, 0);
    run_burst(8'hCD, 0, 8, 0, 1, 0, "R3 R4 R6 seq len8 stalled");
    run_burst(8'h10, 1, 8, 0, 0, 0, "R4 seq len8 write");

    set_mode(3'b010, 1, 0);
    run_burst(8'h1E, 0, 4, 0, 0, 0, "R5 inter len4");
    set_mode(3'b011, 1, 0);
    run_burst(8'h5D, 0, 8, 0, 1, 0, "R5 R6 inter len8");
    set_mode(3'b001, 1, 0);
    run_burst(8'hFF, 0, 2, 0, 0, 0, "R5 inter len2");

    set_mode(3'b100, 0, 0);
    run_burst(8'h42, 0, 1, 0, 0, 0, "R10 code 100");
    set_mode(3'b110, 1, 0);
    run_burst(8'h43, 0, 1, 0, 0, 0, "R10 code 110");

    set_mode(3'b111, 1, 0);
    run_burst(8'hFA, 0, 10, 1, 0, 0, "R7 page wrap");
    set_mode(3'b011, 0, 0);
    run_burst(8'h23, 0, 3, 1, 0, 0, "R9 stop mid len8");

    set_mode(3'b010, 0, 1);
    check(single_write, "R1 single_write set", single_write, 1);
    run_burst(8'h2A, 1, 1, 0, 0, 0, "R11 write one beat");
    run_burst(8'h2A, 0, 4, 0, 0, 0, "R11 read keeps len4");
    set_mode(3'b010, 0, 0);
    check(!single_write, "R1 single_write clear", single_write, 0);

    run_burst(8'h71, 0, 4, 0, 0, 1, "R12 mode write mid burst");
    run_burst(8'h71, 0, 8, 0, 0, 0, "R12 new mode next burst");

    set_mode(3'b011, 0, 0);
    run_burst(8'h00, 0, 2, 2, 0, 0, "R13 first burst");
    run_burst(8'h44, 0, 8, 0, 0, 0, "R13 restarted burst");

    // R9: stop and ready while idle change nothing
    @(posedge clk); #1;
    stop = 1; beat_ready = 1;
    @(posedge clk); #1;
    stop = 0;
    check(!beat_valid, "R9 idle stop/ready", beat_valid, 0);
    check(!last, "R9 idle last", last, 0);
    beat_ready = 0;
    run_burst(8'h09, 0, 8, 0, 0, 0, "R9 after idle stop");

    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule